// File: doc/BRIEF.md
# Packed Colour Palette Lookup

This block is a 256-entry colour palette. It is stored as 128 words of 32 bits, with two 16-bit entries packed into each word. A processor port writes whole words and reads them back exactly as they were stored. A pixel stream sends an 8-bit colour index and receives the matching colour one cycle later. The colour comes out in one of four pixel formats, chosen per request.

Each 16-bit entry holds three 5-bit channels and an intensity flag. The flag is stored but plays no part in the colour output. Each channel is first widened to 8 bits by appending three zero bits. The widened colour is then packed into the format requested.

The pixel side is a valid/ready stream with one result register.
- A request is taken on a clock edge where `pix_valid` and `pix_ready` are both high.
- `pix_ready` is high whenever the result register is empty or is being drained in the same cycle (`col_ready` high).
- While `col_valid` is high and `col_ready` is low, the result holds, and no new request is taken.
- A source may raise `pix_valid` without waiting for `pix_ready`. It must hold its request until it sees `pix_ready`.

Top module: `palette_lut`

## Requirements
- R1: After reset, `col_valid` is 0, `cpu_rdata` is 0 and every stored word reads back as 0.
- R2: A processor write stores `cpu_wdata` at `cpu_addr`. One cycle after a read address is presented, `cpu_rdata` returns the stored word bit for bit, intensity flags included.
- R3: If a write and a read use the same word in the same cycle, the read returns the word as it was before that write.
- R4: An index selects word `index[7:1]`. An even index takes bits 15:0 of that word and an odd index takes bits 31:16.
- R5: Within an entry, red is bits 4:0, green is bits 9:5 and blue is bits 14:10. Bit 15 (intensity) has no effect on the colour.
- R6: Format code 0 (3:3:2) gives `col_data = {16'b0, R8[7:5], G8[7:5], B8[7:6]}`, where X8 is the channel shifted left by 3.
- R7: Format code 1 (5:5:5) gives `col_data = {9'b0, R8[7:3], G8[7:3], B8[7:3]}`.
- R8: Format code 2 (5:6:5) gives `col_data = {8'b0, R8[7:3], G8[7:2], B8[7:3]}`.
- R9: Format code 3 (8:8:8) gives `col_data = {R8, G8, B8}`, with red in bits 23:16, green in 15:8 and blue in 7:0.
- R10: A request accepted on an edge sets `col_valid` after that same edge. If `col_ready` is high and no request is taken, `col_valid` clears.
- R11: `pix_ready` equals `col_ready | ~col_valid`. While `col_valid` is high and `col_ready` is low, `col_valid` and `col_data` stay unchanged.
- R12: A lookup taken in the same cycle as a processor write to the same word returns the colour from the old word.
- R13: The format is sampled when the request is accepted. A later change of `pix_fmt` does not alter a result that is already held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_we | input | 1 | Write strobe for the processor port |
| cpu_addr | input | 7 | Word address for both read and write |
| cpu_wdata | input | 32 | Word to store |
| cpu_rdata | output | 32 | Word at last cycle's `cpu_addr` |
| pix_valid | input | 1 | Lookup request present |
| pix_ready | output | 1 | Lookup request can be taken |
| pix_index | input | 8 | Palette index |
| pix_fmt | input | 2 | Output format code (0 = 3:3:2, 1 = 5:5:5, 2 = 5:6:5, 3 = 8:8:8) |
| col_valid | output | 1 | Colour result present |
| col_ready | input | 1 | Consumer takes the result |
| col_data | output | 24 | Packed colour, zero above the chosen format |

## Verification
The assertions assume that, once reset is released, every input has a known value on each rising edge. In particular they assume `col_ready` and `pix_valid` are never X. The hold and drop properties rely on this, because they treat the handshake signals as plain booleans.

The stimulus changes every input only on the falling edge. It keeps reset low for several cycles before the first transfer and draws format codes only from the four defined values. Back-pressure is applied both with a request waiting and without one. This exercises the hold, accept and drain paths of the result register under conditions the properties take for granted.

// File: rtl/palette_lut_pkg.sv
package palette_lut_pkg;
  localparam int CH_W    = 5;
  localparam int WIDE_W  = 8;
  localparam int ENTRY_W = 16;
  localparam int COL_W   = 24;

  typedef enum logic [1:0] {
    FMT_RGB332 = 2'd0,
    FMT_RGB555 = 2'd1,
    FMT_RGB565 = 2'd2,
    FMT_RGB888 = 2'd3
  } pix_fmt_e;

  // Bit 15 intensity, 14:10 blue, 9:5 green, 4:0 red
  typedef struct packed {
    logic            intens;
    logic [CH_W-1:0] blu;
    logic [CH_W-1:0] grn;
    logic [CH_W-1:0] red;
  } pal_entry_t;

  function automatic logic [WIDE_W-1:0] widen(input logic [CH_W-1:0] c);
    return {c, {(WIDE_W-CH_W){1'b0}}};
  endfunction
endpackage

// File: rtl/pal_word_store.sv
module pal_word_store #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic [WORD_W-1:0] lk_word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  // Lookup reads the pre-edge contents, so a same-cycle write is not seen
  assign lk_word = mem[lk_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      cpu_rdata <= '0;
    end else begin
      cpu_rdata <= mem[cpu_addr];
      if (cpu_we) mem[cpu_addr] <= cpu_wdata;
    end
  end

  // A write followed by a read of the same word returns the written value
  assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && !$past(cpu_we == 1'b1 && 1'b0)) ##1 (cpu_addr == $past(cpu_addr)) && !cpu_we
      |=> cpu_rdata == $past(cpu_wdata, 2))
    else $error("assert_readback_R2");
endmodule

// File: rtl/pal_expand.sv
module pal_expand
  import palette_lut_pkg::*;
(
  input  logic [ENTRY_W-1:0] entry,
  input  logic [1:0]         fmt,
  output logic [COL_W-1:0]   color
);
  pal_entry_t         e;
  logic [WIDE_W-1:0]  r8, g8, b8;

  assign e  = pal_entry_t'(entry);
  assign r8 = widen(e.red);
  assign g8 = widen(e.grn);
  assign b8 = widen(e.blu);

  always_comb begin
    unique case (pix_fmt_e'(fmt))
      FMT_RGB332: color = {16'b0, r8[7:5], g8[7:5], b8[7:6]};
      FMT_RGB555: color = {9'b0,  r8[7:3], g8[7:3], b8[7:3]};
      FMT_RGB565: color = {8'b0,  r8[7:3], g8[7:2], b8[7:3]};
      default:    color = {r8, g8, b8};
    endcase
  end
endmodule

// File: rtl/pal_out_stage.sv
module pal_out_stage #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [1:0]        in_fmt,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic [1:0] fmt_q;
  logic       take;

  assign in_ready = out_ready || !out_valid;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      fmt_q     <= 2'd0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
      fmt_q     <= in_fmt;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data))
    else $error("assert_stall_hold_R11");

  assert_accept_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid)
    else $error("assert_accept_valid_R10");

  assert_drain_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid)
    else $error("assert_drain_clear_R10");

  assert_narrow_top_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && fmt_q != 2'd3 |-> out_data[DATA_W-1 -: 8] == 8'd0)
    else $error("assert_narrow_top_zero_R8");
endmodule

// File: rtl/palette_lut.sv
module palette_lut
  import palette_lut_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int WORD_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cpu_we,
  input  logic [IDX_W-2:0]      cpu_addr,
  input  logic [WORD_W-1:0]     cpu_wdata,
  output logic [WORD_W-1:0]     cpu_rdata,
  input  logic                  pix_valid,
  output logic                  pix_ready,
  input  logic [IDX_W-1:0]      pix_index,
  input  logic [1:0]            pix_fmt,
  output logic                  col_valid,
  input  logic                  col_ready,
  output logic [COL_W-1:0]      col_data
);
  localparam int ADDR_W = IDX_W - 1;
  localparam int HALF_W = WORD_W / 2;

  logic [WORD_W-1:0] lk_word;
  logic [HALF_W-1:0] lk_entry;
  logic [COL_W-1:0]  lk_color;

  pal_word_store #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .lk_addr   (pix_index[IDX_W-1:1]),
    .lk_word   (lk_word)
  );

  // Even index -> low half, odd index -> high half
  assign lk_entry = pix_index[0] ? lk_word[WORD_W-1:HALF_W] : lk_word[HALF_W-1:0];

  pal_expand u_expand (
    .entry (lk_entry[ENTRY_W-1:0]),
    .fmt   (pix_fmt),
    .color (lk_color)
  );

  pal_out_stage #(.DATA_W(COL_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (pix_valid),
    .in_ready  (pix_ready),
    .in_data   (lk_color),
    .in_fmt    (pix_fmt),
    .out_valid (col_valid),
    .out_ready (col_ready),
    .out_data  (col_data)
  );
endmodule

// File: tb/palette_lut_test.sv
`timescale 1ns/1ps
module palette_lut_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_we = 1'b0;
  logic [6:0]  cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        pix_valid = 1'b0;
  logic        pix_ready;
  logic [7:0]  pix_index = '0;
  logic [1:0]  pix_fmt = '0;
  logic        col_valid;
  logic        col_ready = 1'b1;
  logic [23:0] col_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  palette_lut uut (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .pix_index(pix_index), .pix_fmt(pix_fmt),
    .col_valid(col_valid), .col_ready(col_ready), .col_data(col_data)
  );

  // Behavioural reference
  logic [31:0] m_mem [128];
  logic        m_valid;
  logic [23:0] m_color;
  logic [31:0] m_rdata;

  function automatic logic [23:0] ref_color(input logic [15:0] e, input logic [1:0] f);
    int r, g, b, v;
    r = (e % 32) * 8;
    g = ((e / 32) % 32) * 8;
    b = ((e / 1024) % 32) * 8;
    case (f)
      2'd0: v = (r / 32) * 32 + (g / 32) * 4 + b / 64;
      2'd1: v = (r / 8) * 1024 + (g / 8) * 32 + b / 8;
      2'd2: v = (r / 8) * 2048 + (g / 4) * 32 + b / 8;
      default: v = r * 65536 + g * 256 + b;
    endcase
    return v[23:0];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) m_mem[i] <= '0;
      m_valid <= 1'b0;
      m_color <= '0;
      m_rdata <= '0;
    end else begin
      logic [31:0] w;
      m_rdata <= m_mem[cpu_addr];
      w = m_mem[pix_index / 2];
      if (pix_valid && (col_ready || !m_valid)) begin
        m_valid <= 1'b1;
        m_color <= ref_color(pix_index % 2 ? w[31:16] : w[15:0], pix_fmt);
      end else if (col_ready) begin
        m_valid <= 1'b0;
      end
      if (cpu_we) m_mem[cpu_addr] <= cpu_wdata;
    end
  end

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
    end
  endtask

  task automatic compare();
    check("pix_ready", {31'b0, pix_ready}, {31'b0, col_ready || !m_valid});
    check("col_valid", {31'b0, col_valid}, {31'b0, m_valid});
    if (m_valid) check("col_data", {8'b0, col_data}, {8'b0, m_color});
    check("cpu_rdata", cpu_rdata, m_rdata);
  endtask

  task automatic step(input logic we, input logic [6:0] a, input logic [31:0] wd,
                      input logic pv, input logic [7:0] idx, input logic [1:0] f,
                      input logic rdy);
    @(negedge clk);
    cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    pix_valid = pv; pix_index = idx; pix_fmt = f; col_ready = rdy;
    #1;
    compare();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    phase = "R1";
    #1 compare();
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(0, 7'(i), 0, 0, 0, 0, 1);

    phase = "R2";
    for (int i = 0; i < 128; i++) step(1, 7'(i), $urandom | 32'h8000_8000 * (i % 2), 0, 0, 0, 1);
    for (int i = 0; i < 128; i++) step(0, 7'(i), 0, 0, 0, 0, 1);

    phase = "R3";
    step(1, 7'd9, 32'hDEAD_BEEF, 0, 0, 0, 1);
    step(0, 7'd9, 0, 0, 0, 0, 1);
    step(0, 7'd9, 0, 0, 0, 0, 1);

    phase = "R4 R5";
    step(1, 7'd3, 32'h7C1F_83E0, 0, 0, 0, 1);
    step(1, 7'd4, 32'hFFFF_0000, 0, 0, 0, 1);
    for (int i = 6; i < 10; i++) step(0, 0, 0, 1, 8'(i), 2'd3, 1);
    for (int i = 0; i < 64; i++) step(0, 0, 0, 1, 8'($urandom), 2'd3, 1);

    phase = "R6";
    for (int i = 0; i < 64; i++) step(0, 0, 0, 1, 8'($urandom), 2'd0, 1);
    phase = "R7";
    for (int i = 0; i < 64; i++) step(0, 0, 0, 1, 8'($urandom), 2'd1, 1);
    phase = "R8";
    for (int i = 0; i < 64; i++) step(0, 0, 0, 1, 8'($urandom), 2'd2, 1);
    phase = "R9";
    for (int i = 0; i < 64; i++) step(0, 0, 0, 1, 8'($urandom), 2'd3, 1);

    phase = "R10 R11";
    for (int i = 0; i < 400; i++)
      step(0, 0, 0, 1'($urandom), 8'($urandom), 2'($urandom), 1'($urandom));
    step(0, 0, 0, 1, 8'd20, 2'd3, 0);
    step(0, 0, 0, 1, 8'd21, 2'd3, 0);
    step(0, 0, 0, 0, 8'd21, 2'd3, 1);
    step(0, 0, 0, 0, 8'd21, 2'd3, 1);

    phase = "R12";
    step(1, 7'd12, 32'h1234_5678, 1, 8'd24, 2'd3, 1);
    step(1, 7'd12, 32'h0BAD_F00D, 1, 8'd25, 2'd2, 1);
    step(0, 7'd12, 0, 1, 8'd24, 2'd3, 1);

    phase = "R13";
    step(0, 0, 0, 1, 8'd40, 2'd3, 0);
    step(0, 0, 0, 0, 8'd40, 2'd0, 0);
    step(0, 0, 0, 1, 8'd41, 2'd1, 0);
    step(0, 0, 0, 0, 8'd41, 2'd2, 1);

    phase = "mixed R2 R12";
    for (int i = 0; i < 800; i++) begin
      logic [6:0] a;
      a = 7'($urandom);
      step(1'($urandom), a, $urandom, 1'($urandom), {a, 1'($urandom)},
           2'($urandom), 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule